// File: doc/BRIEF.md
# Configuration Header Register Space

This block holds the 64-byte type-zero configuration header of a single-function 32-bit bus device. A host reaches it with configuration accesses: one request cycle that carries the DWORD index (0 to 15), the 4-bit bus command, active-low byte enables, write data and the chip-select line `acc_idsel`. The block claims a request only when the chip-select line is high and the command is a configuration read or a configuration write. For a claimed request it returns an acknowledge one cycle later, together with the read data when the request is a read. Bus timing and address-hit decoding are left to neighbouring logic.

The header contains read-only identity fields set by parameters, and a command register in which four bits are implemented. The status register holds event flags that hardware sets and software clears by writing ones. The header also has a latency timer, one memory base address register, one I/O base address register, and the interrupt line and pin bytes. The block drives the four enable bits and the two programmed base-address fields to the rest of the device.

Top module: `cfg_space_top`

## Requirements
- R1: A request is claimed only when `acc_valid` and `acc_idsel` are both high and `acc_cmd` is 4'b1010 (read) or 4'b1011 (write). Any other request gives no acknowledge and changes no register.
- R2: `rsp_ack` is high in the cycle after a claimed request and low otherwise. `rsp_rdata` holds the addressed DWORD in the cycle after a claimed read and is zero at every other time.
- R3: The read-only fields read back as follows. DWORD 0 is {DEVICE_ID, VENDOR_ID}. DWORD 2 is {CLASS_CODE, REVISION_ID}. DWORD 11 is {SUBSYS_ID, SUBSYS_VENDOR_ID}. Header type (DWORD 3, bits 23:16) is 0x00. Interrupt pin (DWORD 15, bits 15:8) is 0x01. Minimum grant (DWORD 15, bits 23:16) is 0x10. Maximum latency (DWORD 15, bits 31:24) is 0x00.
- R4: The command register is DWORD 1, bits 15:0. Only bit 1 (memory response, `en_mem`), bit 2 (mastering, `en_master`), bit 6 (parity reporting, `en_perr`) and bit 8 (system error reporting, `en_serr`) can be written. Every other bit reads 0. The four enable outputs follow the stored bits.
- R5: The status register is DWORD 1, bits 31:16. Its flags sit at status bit 8 (data parity reported), bit 12 (target abort), bit 13 (master abort), bit 14 (system error signalled) and bit 15 (parity error detected). Writing a 1 clears a flag and writing a 0 leaves it unchanged, so writing 0x4000 to the status register clears only bit 14. Bits 10:9 always read 2'b10 (slow select timing).
- R6: A pulse on an `ev_*` input sets its status flag. The data-parity-reported flag is set only while the parity reporting enable is 1. When a set and a clear reach the same flag in the same cycle, the set wins.
- R7: The latency timer is DWORD 3, bits 15:8. Its bits 7:3 can be written and its bits 2:0 always read 0.
- R8: BAR0 is DWORD 4. Bits 31:20 can be written and appear on `mem_base`. Bits 19:0 read 0, which marks a memory BAR that is 32-bit and not prefetchable.
- R9: BAR1 is DWORD 5. Bits 31:20 can be written and appear on `io_base`. Bit 0 reads 1, bits 19:1 read 0.
- R10: The interrupt line byte (DWORD 15, bits 7:0) can be read and written and resets to 0xFF.
- R11: On a write, byte lane k (data bits 8k+7:8k) is updated only when `acc_be_n[k]` is 0.
- R12: DWORDs that are not implemented (6 to 10, 12 to 14) read as zero, and writes to them change nothing.
- R13: After reset, the command register, the status flags, the latency timer and both BAR fields are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Request present this cycle |
| acc_idsel | input | 1 | Configuration chip select |
| acc_cmd | input | 4 | Bus command of the request |
| acc_idx | input | 4 | DWORD index within the header |
| acc_be_n | input | 4 | Active-low byte enables |
| acc_wdata | input | 32 | Write data |
| ev_par_rep | input | 1 | Event: data parity error reported |
| ev_tgt_abort | input | 1 | Event: target abort |
| ev_mst_abort | input | 1 | Event: master abort |
| ev_sys_err | input | 1 | Event: system error signalled |
| ev_par_det | input | 1 | Event: parity error detected |
| rsp_ack | output | 1 | Claimed request acknowledged (one cycle later) |
| rsp_rdata | output | 32 | Read data |
| en_mem | output | 1 | Memory response enable |
| en_master | output | 1 | Bus mastering enable |
| en_perr | output | 1 | Parity error reporting enable |
| en_serr | output | 1 | System error reporting enable |
| mem_base | output | 12 | Programmed memory base bits 31:20 |
| io_base | output | 12 | Programmed I/O base bits 31:20 |

## Verification
The assertions assume that the event inputs are single-cycle pulses. They also assume that the request fields are stable, known values whenever `acc_valid` is high. The bench drives each request for exactly one cycle at the falling edge, and returns valid and every event line to zero before the next operation. It mixes random indices, byte enables, data and events with requests that must not be claimed (chip select low, or a wrong command). It also checks three directed cases: the full reset map, the 0x4000 clear, and a set that collides with a clear in the same cycle.

// File: rtl/cfg_hdr_pkg.sv
// Package: constants shared by the configuration header block.
// Assumes a 64-byte header made of 32-bit DWORDs.
package cfg_hdr_pkg;
    localparam int HDR_BYTES = 64;
    localparam int NUM_DW    = HDR_BYTES / 4;
    localparam int IDX_W     = $clog2(NUM_DW);

    localparam logic [3:0] CMD_CFG_RD = 4'b1010;
    localparam logic [3:0] CMD_CFG_WR = 4'b1011;

    localparam int DW_IDENT   = 0;
    localparam int DW_CTLSTAT = 1;
    localparam int DW_CLASS   = 2;
    localparam int DW_TIMING  = 3;
    localparam int DW_BAR0    = 4;
    localparam int DW_BAR1    = 5;
    localparam int DW_SUBSYS  = 11;
    localparam int DW_INTR    = 15;

    localparam int ST_DPR  = 8;
    localparam int ST_TABT = 12;
    localparam int ST_MABT = 13;
    localparam int ST_SERR = 14;
    localparam int ST_DPE  = 15;
    localparam logic [15:0] STAT_W1C   = 16'hF100;
    localparam logic [15:0] STAT_FIXED = 16'h0400;

    localparam logic [7:0] HDR_TYPE = 8'h00;
    localparam logic [7:0] INT_PIN  = 8'h01;
    localparam logic [7:0] MIN_GNT  = 8'h10;
    localparam logic [7:0] MAX_LAT  = 8'h00;
endpackage

// File: rtl/cfg_access_dec.sv
// Request decoder: it claims configuration reads and writes that arrive
// with the chip select high, and turns a claimed write into a one-hot DWORD
// select and a per-lane write enable.
// Assumes the request fields are stable whenever acc_valid is high.
module cfg_access_dec
    import cfg_hdr_pkg::*;
(
    input  logic              acc_valid,
    input  logic              acc_idsel,
    input  logic [3:0]        acc_cmd,
    input  logic [IDX_W-1:0]  acc_idx,
    input  logic [3:0]        acc_be_n,
    output logic              claim,
    output logic              rd_hit,
    output logic [NUM_DW-1:0] wr_dw,
    output logic [3:0]        lane_we
);
    logic wr_hit;

    // Qualify the request with the chip select and the command code.
    always_comb begin
        rd_hit = acc_valid && acc_idsel && (acc_cmd == CMD_CFG_RD);
        wr_hit = acc_valid && acc_idsel && (acc_cmd == CMD_CFG_WR);
        claim  = rd_hit || wr_hit;
    end

    // One select line per DWORD, built by a generate loop.
    for (genvar d = 0; d < NUM_DW; d++) begin : g_dwsel
        assign wr_dw[d] = wr_hit && (acc_idx == IDX_W'(d));
    end

    // Byte enables are active low; a lane is written only on a claimed write.
    assign lane_we = wr_hit ? ~acc_be_n : 4'b0000;
endmodule

// File: rtl/cfg_regs.sv
// Storage for the writable header fields: the command enables, the status
// flags (written one to clear), the latency timer, the BAR fields and the
// interrupt line.
// Assumes each ev_* input is a single-cycle pulse from device logic.
module cfg_regs
    import cfg_hdr_pkg::*;
#(
    parameter int BAR_BITS = 12,
    parameter int NUM_BARS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_DW-1:0]   wr_dw,
    input  logic [3:0]          lane_we,
    input  logic [31:0]         wdata,
    input  logic                ev_par_rep,
    input  logic                ev_tgt_abort,
    input  logic                ev_mst_abort,
    input  logic                ev_sys_err,
    input  logic                ev_par_det,
    output logic                cmd_mem,
    output logic                cmd_mst,
    output logic                cmd_perr,
    output logic                cmd_serr,
    output logic [15:0]         stat_q,
    output logic [4:0]          lat_q,
    output logic [BAR_BITS-1:0] bar_q [NUM_BARS],
    output logic [7:0]          intln_q
);
    localparam int BAR_LO = 32 - BAR_BITS;

    logic [15:0] stat_clr;
    logic [15:0] stat_set;
    logic        unused_wbits;

    assign unused_wbits = ^wdata;

    // Command enables: lane 0 holds bits 1, 2 and 6; lane 1 holds bit 8.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_mem  <= 1'b0;
            cmd_mst  <= 1'b0;
            cmd_perr <= 1'b0;
            cmd_serr <= 1'b0;
        end else if (wr_dw[DW_CTLSTAT]) begin
            if (lane_we[0]) begin
                cmd_mem  <= wdata[1];
                cmd_mst  <= wdata[2];
                cmd_perr <= wdata[6];
            end
            if (lane_we[1]) cmd_serr <= wdata[8];
        end
    end

    // Build the clear mask (write ones, by lane) and the set mask (events).
    always_comb begin
        stat_clr = '0;
        if (wr_dw[DW_CTLSTAT])
            stat_clr = wdata[31:16] & {{8{lane_we[3]}}, {8{lane_we[2]}}} & STAT_W1C;
        stat_set = '0;
        stat_set[ST_DPR]  = ev_par_rep && cmd_perr;
        stat_set[ST_TABT] = ev_tgt_abort;
        stat_set[ST_MABT] = ev_mst_abort;
        stat_set[ST_SERR] = ev_sys_err;
        stat_set[ST_DPE]  = ev_par_det;
    end

    // Status flags: clear first, then set, so a set in the same cycle wins.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~stat_clr) | stat_set;
    end

    // Latency timer: only bits 7:3 of byte lane 1 are stored.
    always_ff @(posedge clk) begin
        if (!rst_n)                               lat_q <= '0;
        else if (wr_dw[DW_TIMING] && lane_we[1])  lat_q <= wdata[15:11];
    end

    // BAR fields: every stored bit follows the enable of its own byte lane.
    for (genvar g = 0; g < NUM_BARS; g++) begin : g_bar
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bar_q[g] <= '0;
            end else if (wr_dw[DW_BAR0 + g]) begin
                for (int b = 0; b < BAR_BITS; b++) begin
                    if (lane_we[(BAR_LO + b) / 8]) bar_q[g][b] <= wdata[BAR_LO + b];
                end
            end
        end
    end

    // Interrupt line byte in lane 0 of the last DWORD.
    always_ff @(posedge clk) begin
        if (!rst_n)                             intln_q <= 8'hFF;
        else if (wr_dw[DW_INTR] && lane_we[0])  intln_q <= wdata[7:0];
    end

    AST_DPR_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_q[ST_DPR]) |-> $past(cmd_perr)); // R6
    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_dw[DW_CTLSTAT] |=> $stable({cmd_mem, cmd_mst, cmd_perr, cmd_serr})); // R4
    AST_STAT_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev_par_rep || ev_tgt_abort || ev_mst_abort || ev_sys_err || ev_par_det)
        |=> ((stat_q & ~$past(stat_q)) == 16'h0000)); // R5
    AST_BAR0_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_dw[DW_BAR0] |=> $stable(bar_q[0])); // R8
    AST_BAR1_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_dw[DW_BAR1] |=> $stable(bar_q[1])); // R9
    AST_INTLN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_dw[DW_INTR] |=> $stable(intln_q)); // R10
endmodule

// File: rtl/cfg_rd_mux.sv
// Read path: it selects the addressed DWORD, fills in the fixed fields and
// registers the data and the acknowledge for one cycle.
// Assumes the index is valid whenever rd_hit is high.
module cfg_rd_mux
    import cfg_hdr_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID        = 16'hFACE,
    parameter logic [15:0] DEVICE_ID        = 16'h0001,
    parameter logic [23:0] CLASS_CODE       = 24'hFF0000,
    parameter logic [7:0]  REVISION_ID      = 8'h01,
    parameter logic [15:0] SUBSYS_ID        = 16'h0000,
    parameter logic [15:0] SUBSYS_VENDOR_ID = 16'h0000,
    parameter int          BAR_BITS         = 12,
    parameter int          NUM_BARS         = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                claim,
    input  logic                rd_hit,
    input  logic [IDX_W-1:0]    idx,
    input  logic                cmd_mem,
    input  logic                cmd_mst,
    input  logic                cmd_perr,
    input  logic                cmd_serr,
    input  logic [15:0]         stat_q,
    input  logic [4:0]          lat_q,
    input  logic [BAR_BITS-1:0] bar_q [NUM_BARS],
    input  logic [7:0]          intln_q,
    output logic                ack_q,
    output logic [31:0]         rdata_q
);
    localparam int BAR_LO = 32 - BAR_BITS;

    logic [15:0] cmd_word;
    logic [31:0] rd_val;

    // Place the four command bits at their register positions.
    always_comb begin
        cmd_word    = '0;
        cmd_word[1] = cmd_mem;
        cmd_word[2] = cmd_mst;
        cmd_word[6] = cmd_perr;
        cmd_word[8] = cmd_serr;
    end

    // Select the addressed DWORD; unimplemented indices give zero.
    always_comb begin
        rd_val = '0;
        case (int'(idx))
            DW_IDENT:   rd_val = {DEVICE_ID, VENDOR_ID};
            DW_CTLSTAT: rd_val = {stat_q | STAT_FIXED, cmd_word};
            DW_CLASS:   rd_val = {CLASS_CODE, REVISION_ID};
            DW_TIMING:  rd_val = {8'h00, HDR_TYPE, lat_q, 3'b000, 8'h00};
            DW_BAR0:    rd_val = {bar_q[0], {BAR_LO{1'b0}}};
            DW_BAR1:    rd_val = {bar_q[1], {BAR_LO{1'b0}}} | 32'h0000_0001;
            DW_SUBSYS:  rd_val = {SUBSYS_ID, SUBSYS_VENDOR_ID};
            DW_INTR:    rd_val = {MAX_LAT, MIN_GNT, INT_PIN, intln_q};
            default:    rd_val = '0;
        endcase
    end

    // Register the response; the data is zero unless a read was claimed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            ack_q   <= claim;
            rdata_q <= rd_hit ? rd_val : '0;
        end
    end

    AST_DATA_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_hit) |-> (rdata_q == 32'h0)); // R2
    AST_SLOW_TIMING_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_hit) && ($past(idx) == IDX_W'(DW_CTLSTAT))) |-> (rdata_q[26:25] == 2'b10)); // R5
endmodule

// File: rtl/cfg_space_top.sv
// Top of the configuration header: decoder, register storage and read path.
// Assumes single-cycle requests, and that the events are pulses in the clock domain.
module cfg_space_top
    import cfg_hdr_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID        = 16'hFACE,
    parameter logic [15:0] DEVICE_ID        = 16'h0001,
    parameter logic [23:0] CLASS_CODE       = 24'hFF0000,
    parameter logic [7:0]  REVISION_ID      = 8'h01,
    parameter logic [15:0] SUBSYS_ID        = 16'h0000,
    parameter logic [15:0] SUBSYS_VENDOR_ID = 16'h0000,
    parameter int          BAR_BITS         = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_valid,
    input  logic                acc_idsel,
    input  logic [3:0]          acc_cmd,
    input  logic [IDX_W-1:0]    acc_idx,
    input  logic [3:0]          acc_be_n,
    input  logic [31:0]         acc_wdata,
    input  logic                ev_par_rep,
    input  logic                ev_tgt_abort,
    input  logic                ev_mst_abort,
    input  logic                ev_sys_err,
    input  logic                ev_par_det,
    output logic                rsp_ack,
    output logic [31:0]         rsp_rdata,
    output logic                en_mem,
    output logic                en_master,
    output logic                en_perr,
    output logic                en_serr,
    output logic [BAR_BITS-1:0] mem_base,
    output logic [BAR_BITS-1:0] io_base
);
    localparam int NUM_BARS = 2;

    logic                claim;
    logic                rd_hit;
    logic [NUM_DW-1:0]   wr_dw;
    logic [3:0]          lane_we;
    logic [15:0]         stat_q;
    logic [4:0]          lat_q;
    logic [BAR_BITS-1:0] bar_q [NUM_BARS];
    logic [7:0]          intln_q;

    cfg_access_dec u_dec (
        .acc_valid (acc_valid),
        .acc_idsel (acc_idsel),
        .acc_cmd   (acc_cmd),
        .acc_idx   (acc_idx),
        .acc_be_n  (acc_be_n),
        .claim     (claim),
        .rd_hit    (rd_hit),
        .wr_dw     (wr_dw),
        .lane_we   (lane_we)
    );

    cfg_regs #(.BAR_BITS(BAR_BITS), .NUM_BARS(NUM_BARS)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_dw        (wr_dw),
        .lane_we      (lane_we),
        .wdata        (acc_wdata),
        .ev_par_rep   (ev_par_rep),
        .ev_tgt_abort (ev_tgt_abort),
        .ev_mst_abort (ev_mst_abort),
        .ev_sys_err   (ev_sys_err),
        .ev_par_det   (ev_par_det),
        .cmd_mem      (en_mem),
        .cmd_mst      (en_master),
        .cmd_perr     (en_perr),
        .cmd_serr     (en_serr),
        .stat_q       (stat_q),
        .lat_q        (lat_q),
        .bar_q        (bar_q),
        .intln_q      (intln_q)
    );

    cfg_rd_mux #(
        .VENDOR_ID        (VENDOR_ID),
        .DEVICE_ID        (DEVICE_ID),
        .CLASS_CODE       (CLASS_CODE),
        .REVISION_ID      (REVISION_ID),
        .SUBSYS_ID        (SUBSYS_ID),
        .SUBSYS_VENDOR_ID (SUBSYS_VENDOR_ID),
        .BAR_BITS         (BAR_BITS),
        .NUM_BARS         (NUM_BARS)
    ) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .claim    (claim),
        .rd_hit   (rd_hit),
        .idx      (acc_idx),
        .cmd_mem  (en_mem),
        .cmd_mst  (en_master),
        .cmd_perr (en_perr),
        .cmd_serr (en_serr),
        .stat_q   (stat_q),
        .lat_q    (lat_q),
        .bar_q    (bar_q),
        .intln_q  (intln_q),
        .ack_q    (rsp_ack),
        .rdata_q  (rsp_rdata)
    );

    // Drive the programmed base fields out of the block.
    assign mem_base = bar_q[0];
    assign io_base  = bar_q[1];

    AST_ACK_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ack |-> $past(acc_valid && acc_idsel)); // R1
    AST_ACK_NEEDS_CFG_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ack |-> ($past(acc_cmd) == CMD_CFG_RD || $past(acc_cmd) == CMD_CFG_WR)); // R1
    AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_idsel && acc_cmd == CMD_CFG_RD) |=> rsp_ack); // R2
endmodule

// File: tb/cfg_space_top_tb.sv
module cfg_space_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0, acc_idsel = 1'b0;
    logic [3:0]  acc_cmd = 4'h0, acc_idx = 4'h0, acc_be_n = 4'hF;
    logic [31:0] acc_wdata = '0;
    logic        ev_par_rep = 0, ev_tgt_abort = 0, ev_mst_abort = 0, ev_sys_err = 0, ev_par_det = 0;
    logic        rsp_ack, en_mem, en_master, en_perr, en_serr;
    logic [31:0] rsp_rdata;
    logic [11:0] mem_base, io_base;

    int total = 0, bad = 0;

    // Reference state kept by the bench.
    logic [15:0] m_cmd, m_stat;
    logic [7:0]  m_lat, m_intln;
    logic [11:0] m_bar0, m_bar1;

    always #10 clk = ~clk;

    cfg_space_top u_dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_idsel(acc_idsel),
        .acc_cmd(acc_cmd), .acc_idx(acc_idx), .acc_be_n(acc_be_n), .acc_wdata(acc_wdata),
        .ev_par_rep(ev_par_rep), .ev_tgt_abort(ev_tgt_abort), .ev_mst_abort(ev_mst_abort),
        .ev_sys_err(ev_sys_err), .ev_par_det(ev_par_det), .rsp_ack(rsp_ack),
        .rsp_rdata(rsp_rdata), .en_mem(en_mem), .en_master(en_master), .en_perr(en_perr),
        .en_serr(en_serr), .mem_base(mem_base), .io_base(io_base)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(input logic [3:0] idx);
        case (idx)
            4'd0:  return 32'h0001_FACE;
            4'd1:  return {m_stat | 16'h0400, m_cmd};
            4'd2:  return 32'hFF00_0001;
            4'd3:  return {16'h0000, m_lat, 8'h00};
            4'd4:  return {m_bar0, 20'h0};
            4'd5:  return {m_bar1, 20'h1};
            4'd11: return 32'h0000_0000;
            4'd15: return {24'h00_10_01, m_intln};
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw, input logic [3:0] be_n);
        logic [31:0] r = old;
        for (int k = 0; k < 4; k++) if (!be_n[k]) r[8*k +: 8] = nw[8*k +: 8];
        return r;
    endfunction

    // Update the reference state for a claimed write.
    task automatic model_write(input logic [3:0] idx, input logic [3:0] be_n, input logic [31:0] d,
                               input logic [15:0] set_now);
        logic [31:0] m;
        logic [15:0] clr;
        case (idx)
            4'd1: begin
                m = merge({16'h0, m_cmd}, d, be_n);
                clr = d[31:16] & {{8{!be_n[3]}}, {8{!be_n[2]}}} & 16'hF100;
                m_stat = (m_stat & ~clr) | set_now;
                m_cmd = m[15:0] & 16'h0146;
            end
            4'd3: begin m = merge({16'h0, m_lat, 8'h0}, d, be_n); m_lat = m[15:8] & 8'hF8; end
            4'd4: begin m = merge({m_bar0, 20'h0}, d, be_n); m_bar0 = m[31:20]; end
            4'd5: begin m = merge({m_bar1, 20'h0}, d, be_n); m_bar1 = m[31:20]; end
            4'd15: begin m = merge({24'h0, m_intln}, d, be_n); m_intln = m[7:0]; end
            default: ;
        endcase
    endtask

    // One request cycle; the response is sampled at the next falling edge.
    task automatic access(input logic sel, input logic [3:0] cmd, input logic [3:0] idx,
                          input logic [3:0] be_n, input logic [31:0] d);
        acc_valid = 1'b1; acc_idsel = sel; acc_cmd = cmd; acc_idx = idx;
        acc_be_n = be_n; acc_wdata = d;
        @(negedge clk);
        acc_valid = 1'b0; acc_idsel = 1'b0; acc_cmd = 4'h0; acc_be_n = 4'hF;
    endtask

    task automatic do_write(input logic [3:0] idx, input logic [3:0] be_n, input logic [31:0] d);
        access(1'b1, 4'b1011, idx, be_n, d);
        model_write(idx, be_n, d, 16'h0);
        check("R2 write ack", {31'h0, rsp_ack}, 32'h1);
    endtask

    task automatic do_read(input logic [3:0] idx, input string req);
        logic [31:0] e = exp_rd(idx);
        access(1'b1, 4'b1010, idx, 4'hF, 32'h0);
        check("R2 read ack", {31'h0, rsp_ack}, 32'h1);
        check(req, rsp_rdata, e);
    endtask

    task automatic pulse_ev(input logic [4:0] ev);
        {ev_par_det, ev_sys_err, ev_mst_abort, ev_tgt_abort, ev_par_rep} = ev;
        @(negedge clk);
        {ev_par_det, ev_sys_err, ev_mst_abort, ev_tgt_abort, ev_par_rep} = 5'b0;
        m_stat = m_stat | {ev[4], ev[3], ev[2], ev[1], 3'b000, ev[0] & m_cmd[6], 8'h00};
    endtask

    task automatic check_outs();
        check("R4 enables", {28'h0, en_serr, en_perr, en_master, en_mem},
              {28'h0, m_cmd[8], m_cmd[6], m_cmd[2], m_cmd[1]});
        check("R8 mem_base", {20'h0, mem_base}, {20'h0, m_bar0});
        check("R9 io_base", {20'h0, io_base}, {20'h0, m_bar1});
    endtask

    initial begin
        #4_000_000;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        m_cmd = 0; m_stat = 0; m_lat = 0; m_intln = 8'hFF; m_bar0 = 0; m_bar1 = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R13, R3, R12, R10: the whole map after reset.
        check("R2 idle rdata", rsp_rdata, 32'h0);
        check_outs();
        for (int i = 0; i < 16; i++) do_read(4'(i), "R13 R3 R12 reset map");

        // R4: only the implemented command bits stick.
        do_write(4'd1, 4'b1100, 32'h0000_FFFF);
        do_read(4'd1, "R4 command mask");
        check_outs();

        // R5: set every flag, then a write of 0x4000 clears bit 14 only.
        pulse_ev(5'b11111);
        do_read(4'd1, "R6 events set flags");
        do_write(4'd1, 4'b0011, 32'h4000_0000);
        do_read(4'd1, "R5 write 0x4000 clears bit 14 only");

        // R6: a set and a clear in the same cycle; the set wins.
        ev_mst_abort = 1'b1;
        access(1'b1, 4'b1011, 4'd1, 4'b0011, 32'h2000_0000);
        ev_mst_abort = 1'b0;
        model_write(4'd1, 4'b0011, 32'h2000_0000, 16'h2000);
        do_read(4'd1, "R6 set beats clear");

        // R6: parity reported is gated by the enable bit.
        do_write(4'd1, 4'b1100, 32'h0);
        do_write(4'd1, 4'b0011, 32'hFFFF_0000);
        pulse_ev(5'b00001);
        do_read(4'd1, "R6 parity report gated");

        // R1: wrong command and chip select low are not claimed.
        access(1'b1, 4'b0011, 4'd15, 4'h0, 32'h0);
        check("R1 bad command no ack", {31'h0, rsp_ack}, 32'h0);
        access(1'b0, 4'b1011, 4'd15, 4'h0, 32'h0);
        check("R1 idsel low no ack", {31'h0, rsp_ack}, 32'h0);
        check("R2 rdata zero unclaimed", rsp_rdata, 32'h0);
        do_read(4'd15, "R1 R10 interrupt line untouched");

        // Random mix.
        for (int n = 0; n < 600; n++) begin
            int r = int'($urandom % 10);
            logic [3:0] idx = 4'($urandom);
            logic [3:0] be = 4'($urandom);
            logic [31:0] d = $urandom;
            if (r < 4) begin
                do_write(idx, be, d);
            end else if (r < 7) begin
                do_read(idx, "R7 R8 R9 R11 R12 random read");
                check_outs();
            end else if (r == 7) begin
                if ($urandom % 2) access(1'b0, 4'b1011, idx, be, d);
                else access(1'b1, (4'($urandom) & 4'b0111), idx, be, d);
                check("R1 unclaimed no ack", {31'h0, rsp_ack}, 32'h0);
                do_read(idx, "R1 unclaimed no effect");
            end else begin
                pulse_ev(5'($urandom));
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule